// File: doc/BRIEF.md
# Fractional Fixed-Point Multiply-Accumulate Unit

This block is the arithmetic core of a signal-processing datapath. Each cycle it takes two signed fractional operands (two's complement, binary point directly below the sign bit), multiplies them, and folds the product into a wide accumulator. The accumulator has guard bits above the product, so a long run of sums can go past unity for a while and come back into range without losing information. One operation completes every clock.

A 3-bit opcode picks the operation for the cycle: idle, clear, accumulate, subtract-accumulate, load (clear and accumulate in one cycle), or store. A store turns the accumulator into an operand-width result. The unit first rounds the result by truncation, by round-half-up, or by round-half-to-even, as chosen by a 2-bit select. It then clamps the result to the representable range. The result and a one-cycle valid strobe appear on the clock edge after the store. Coefficient and sample fetch, and all loop control, belong to the surrounding logic.

Top module: `fxp_mac`

## Requirements
- R1: After reset the accumulator is zero, `res_o` is zero and `res_vld_o` is low.
- R2: The product of operands a and b, each in signed Q1.(W-1) format, is the exact 2W-bit two's-complement value 2·a·b. The single exception is a = b = most negative, whose product is clamped to 2^(2W-1)-1.
- R3: Opcode 1 (clear) sets the accumulator to zero.
- R4: Opcode 2 (accumulate) adds the sign-extended product to the accumulator. The accumulator is 2W+G bits wide and wraps modulo 2^(2W+G). One such operation completes every cycle.
- R5: Opcode 3 (subtract-accumulate) subtracts the sign-extended product from the accumulator, with the same wrap.
- R6: Opcode 4 (load) replaces the accumulator with the sign-extended product of the same cycle.
- R7: Opcodes 0 (idle), 5 (store), 6 and 7 leave the accumulator unchanged.
- R8: Opcode 5 (store) sets `res_vld_o` high for exactly the following cycle, with the new `res_o`. In every other cycle `res_vld_o` is low and `res_o` keeps its value.
- R9: Rounding select 0 (and the unused code 3) truncates: the result is floor(acc / 2^W), taken from accumulator bits [2W-1:W] and above.
- R10: Rounding select 1 rounds to nearest. If the discarded W low bits are at or above half of one result LSB, the value rounds up (toward positive infinity); below half, it is truncated.
- R11: Rounding select 2 rounds convergently. Discarded bits above half round up and bits below half round down. At exactly half, the value rounds up only if the kept LSB is 1, so the stored LSB is always 0 in that case.
- R12: After rounding, a value above 2^(W-1)-1 stores as 2^(W-1)-1 and a value below -2^(W-1) stores as -2^(W-1). This covers overflow held in the guard bits and overflow caused by rounding itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation select for this cycle |
| rnd_i | input | 2 | Rounding select, used on a store |
| a_i | input | DATA_W | Signed fractional operand A |
| b_i | input | DATA_W | Signed fractional operand B |
| res_o | output | DATA_W | Rounded, saturated stored result |
| res_vld_o | output | 1 | High for one cycle after each store |

## Verification
The accumulator is hidden, so a wrong accumulator state shows up only at the next store, one cycle after the store opcode. It then persists in every later store until a clear or load overwrites it. A product error in the low bits is visible only through rounding decisions. For that reason the bench mixes all three rounding selects across an almost complete sweep of operand pairs and a long pseudo-random operation stream. It also places accumulator values exactly on the half-LSB tie and at the saturation edges, where a wrong carry or guard-bit compare changes the stored word immediately.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLR   = 3'd1,
    OP_MAC   = 3'd2,
    OP_MSU   = 3'd3,
    OP_LOAD  = 3'd4,
    OP_STORE = 3'd5
  } mac_op_e;

  typedef enum logic [1:0] {
    RND_TRUNC   = 2'd0,
    RND_NEAREST = 2'd1,
    RND_CONV    = 2'd2
  } rnd_mode_e;
endpackage

// File: rtl/fxp_mac_mult.sv
module fxp_mac_mult #(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0]   a_i,
  input  logic signed [DATA_W-1:0]   b_i,
  output logic signed [2*DATA_W-1:0] prod_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] OP_MIN   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [PROD_W-1:0] PROD_MAX = {1'b0, {(PROD_W-1){1'b1}}};

  logic signed [PROD_W-1:0] full;
  logic                     both_min;

  always_comb begin
    full     = a_i * b_i;
    both_min = (a_i == OP_MIN) && (b_i == OP_MIN);
    // drop the duplicate sign bit; -1 x -1 cannot be represented
    prod_o   = both_min ? PROD_MAX : (full <<< 1);
  end
endmodule

// File: rtl/fxp_mac_acc.sv
module fxp_mac_acc
  import fxp_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [2:0]                            op_i,
  input  logic [2*DATA_W-1:0]                   prod_i,
  output logic [2*DATA_W+GUARD_W-1:0]           acc_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic [ACC_W-1:0] acc_q, acc_d, prod_ext;

  assign prod_ext = {{GUARD_W{prod_i[PROD_W-1]}}, prod_i};

  always_comb begin
    case (op_i)
      OP_CLR:  acc_d = '0;
      OP_MAC:  acc_d = acc_q + prod_ext;
      OP_MSU:  acc_d = acc_q - prod_ext;
      OP_LOAD: acc_d = prod_ext;
      default: acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CLR) |=> (acc_o == '0)); // R3
  AST_MAC_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MAC) |=> (acc_o == $past(acc_o) + {{GUARD_W{$past(prod_i[PROD_W-1])}}, $past(prod_i)})); // R4
  AST_MSU_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MSU) |=> (acc_o == $past(acc_o) - {{GUARD_W{$past(prod_i[PROD_W-1])}}, $past(prod_i)})); // R5
  AST_LOAD_PROD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (acc_o[PROD_W-1:0] == $past(prod_i))); // R6
  AST_HOLD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_NOP || op_i == OP_STORE || op_i[2:1] == 2'b11) |=> $stable(acc_o)); // R7
endmodule

// File: rtl/fxp_mac_round_sat.sv
module fxp_mac_round_sat
  import fxp_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 8
) (
  input  logic [2*DATA_W+GUARD_W-1:0] acc_i,
  input  logic [1:0]                  mode_i,
  output logic [DATA_W-1:0]           res_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int ACC_W  = 2 * DATA_W + GUARD_W;
  localparam int KEEP_W = ACC_W - DATA_W;
  localparam int HI_W   = KEEP_W - DATA_W + 2;
  localparam logic [DATA_W-1:0] RES_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] RES_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [KEEP_W-1:0] kept;
  logic              half_bit, rest_nz, inc;
  logic [KEEP_W:0]   sum;
  logic [HI_W-1:0]   hi;
  logic              fits;

  always_comb begin
    kept     = acc_i[ACC_W-1:DATA_W];
    half_bit = acc_i[DATA_W-1];
    rest_nz  = |acc_i[DATA_W-2:0];
    case (mode_i)
      RND_NEAREST: inc = half_bit;
      RND_CONV:    inc = half_bit & (rest_nz | kept[0]);
      default:     inc = 1'b0;
    endcase
    sum  = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, inc};
    hi   = sum[KEEP_W:DATA_W-1];
    fits = (hi == '0) || (hi == '1);
    if (fits)            res_o = sum[DATA_W-1:0];
    else if (sum[KEEP_W]) res_o = RES_MIN;
    else                 res_o = RES_MAX;
  end
endmodule

// File: rtl/fxp_mac.sv
module fxp_mac
  import fxp_mac_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int GUARD_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               op_i,
  input  logic [1:0]               rnd_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0]        res_o,
  output logic                     res_vld_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int PROD_W = 2 * DATA_W;
  localparam int ACC_W  = PROD_W + GUARD_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         acc;
  logic [DATA_W-1:0]        res_next;

  fxp_mac_mult #(.DATA_W(DATA_W)) u_mult (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  fxp_mac_acc #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op_i),
    .prod_i (prod),
    .acc_o  (acc)
  );

  fxp_mac_round_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_rnd (
    .acc_i  (acc),
    .mode_i (rnd_i),
    .res_o  (res_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= (op_i == OP_STORE);
      if (op_i == OP_STORE) res_o <= res_next;
    end
  end

  AST_PROD_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i != '0 && b_i != '0) |-> (prod[PROD_W-1] == (a_i[DATA_W-1] ^ b_i[DATA_W-1]))); // R2
  AST_PROD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_i == '0 || b_i == '0) |-> (prod == '0)); // R2
  AST_VLD_AFTER_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STORE) |=> res_vld_o); // R8
  AST_RES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_STORE) |=> (!res_vld_o && $stable(res_o))); // R8
endmodule

// File: tb/tb_fxp_mac.sv
module tb_fxp_mac;
  timeunit 1ns; timeprecision 1ps;

  localparam int DW    = 8;
  localparam int GW    = 4;
  localparam int ACC_W = 2 * DW + GW;
  localparam longint ACC_MOD = longint'(1) << ACC_W;
  localparam int MINV  = -(1 << (DW - 1));
  localparam int MAXV  = (1 << (DW - 1)) - 1;
  localparam int PMAX  = (1 << (2 * DW - 1)) - 1;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [2:0]           op_i = '0;
  logic [1:0]           rnd_i = '0;
  logic signed [DW-1:0] a_i = '0;
  logic signed [DW-1:0] b_i = '0;
  logic [DW-1:0]        res_o;
  logic                 res_vld_o;

  int     n_chk = 0;
  int     n_fail = 0;
  longint macc = 0;
  int     exp_res = 0;
  bit     exp_vld = 1'b0;
  int unsigned lfsr = 32'h1ACE_B00C;

  fxp_mac #(.DATA_W(DW), .GUARD_W(GW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .rnd_i(rnd_i),
    .a_i(a_i), .b_i(b_i), .res_o(res_o), .res_vld_o(res_vld_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic longint wrap(input longint v);
    longint r = v % ACC_MOD;
    if (r < 0) r += ACC_MOD;
    if (r >= ACC_MOD / 2) r -= ACC_MOD;
    return r;
  endfunction

  function automatic int model_prod(input int a, input int b);
    if (a == MINV && b == MINV) return PMAX;
    return 2 * a * b;
  endfunction

  function automatic int model_round(input longint acc, input int md);
    longint kept = acc >>> DW;
    longint low  = acc - (kept << DW);
    longint half = longint'(1) << (DW - 1);
    longint r    = kept;
    if (md == 1 && low >= half) r = kept + 1;
    if (md == 2 && (low > half || (low == half && kept[0]))) r = kept + 1;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int op, input int ai, input int bi, input int md, input string tag);
    int p;
    @(negedge clk_i);
    op_i  = op[2:0];
    a_i   = ai[DW-1:0];
    b_i   = bi[DW-1:0];
    rnd_i = md[1:0];
    p = model_prod(ai, bi);
    if (op == 5) exp_res = model_round(macc, md);
    exp_vld = (op == 5);
    case (op)
      1: macc = 0;
      2: macc = wrap(macc + p);
      3: macc = wrap(macc - p);
      4: macc = wrap(p);
      default: ;
    endcase
    @(posedge clk_i);
    #1;
    check(res_vld_o == exp_vld, "R8 valid", int'(res_vld_o), int'(exp_vld));
    check($signed(res_o) == exp_res, tag, int'($signed(res_o)), exp_res);
  endtask

  function automatic int unsigned nxt(input int unsigned s);
    int unsigned x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check(res_o == '0, "R1 result", int'(res_o), 0);
    check(res_vld_o == 1'b0, "R1 valid", int'(res_vld_o), 0);
    step(5, 0, 0, 0, "R1 acc zero");

    // R2: product sweep, each load stored under a rotating rounding select
    for (int ai = MINV; ai <= MAXV; ai++) begin
      for (int bi = MINV; bi <= MAXV + 7; bi += 7) begin
        int bb = (bi > MAXV) ? MAXV : bi;
        step(4, ai, bb, 0, "R6 load");
        step(5, 0, 0, (ai + bb) & 3, "R2 product");
      end
    end

    // R3: clear
    step(4, MAXV, MAXV, 0, "R6 load");
    step(1, 0, 0, 0, "R3 clear");
    step(5, 0, 0, 1, "R3 cleared");

    // half-LSB ties
    step(4, 1, 64, 0, "R6 load");
    step(5, 0, 0, 0, "R9 trunc tie");
    step(5, 0, 0, 1, "R10 nearest tie up");
    step(5, 0, 0, 2, "R11 conv tie even down");
    step(5, 0, 0, 3, "R9 code3 truncates");
    step(4, 3, 64, 0, "R6 load");
    step(5, 0, 0, 0, "R9 trunc");
    step(5, 0, 0, 1, "R10 nearest");
    step(5, 0, 0, 2, "R11 conv tie odd up");
    step(4, 1, -64, 0, "R6 load");
    step(5, 0, 0, 0, "R9 trunc negative");
    step(5, 0, 0, 1, "R10 nearest negative tie");
    step(5, 0, 0, 2, "R11 conv negative tie");

    // R12: guard-bit overflow both ways
    step(4, MAXV, MAXV, 0, "R6 load");
    step(2, MAXV, MAXV, 0, "R4 mac");
    step(5, 0, 0, 0, "R12 positive clamp");
    step(1, 0, 0, 0, "R3 clear");
    step(3, MAXV, MAXV, 0, "R5 msu");
    step(3, MAXV, MAXV, 0, "R5 msu");
    step(5, 0, 0, 2, "R12 negative clamp");
    // R12: overflow produced by rounding
    step(4, MAXV, MAXV, 0, "R6 load");
    step(2, 1, MAXV, 0, "R4 mac");
    step(2, 1, 64, 0, "R4 mac");
    step(5, 0, 0, 0, "R9 trunc at top");
    step(5, 0, 0, 1, "R12 round overflow nearest");
    step(5, 0, 0, 2, "R12 round overflow conv");
    // R2: most negative squared
    step(4, MINV, MINV, 0, "R6 load");
    step(5, 0, 0, 0, "R2 min squared");
    step(5, 0, 0, 1, "R12 min squared rounded");

    // random operation stream including unused opcodes
    step(1, 0, 0, 0, "R3 clear");
    for (int i = 0; i < 30000; i++) begin
      int op, ai, bi, md;
      lfsr = nxt(lfsr);
      op = int'(lfsr[2:0]);
      md = int'(lfsr[4:3]);
      ai = int'($signed(lfsr[15:8]));
      bi = int'($signed(lfsr[23:16]));
      if (lfsr[31:28] == 4'hF) op = 1;
      step(op, ai, bi, md, "R4 R5 R6 R7 R9 R10 R11 R12 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule